// File: doc/BRIEF.md
# RFID Transponder Readout Encoder

This block turns the stored contents of a passive transponder into the on/off pattern for its load modulator. It runs on the clock recovered from the reader's carrier. It walks one of three content streams bit by bit with no gap: the user memory of 8 words by 16 bits, a 64-bit fixed identifier, or a 128-bit configuration stream. Each bit is coded as Manchester or as bi-phase, and one bit lasts 64 or 32 carrier clocks. Static inputs select the coding and the bit length.

The memory array stays outside the block. The block shows the word address and bit index of the bit it will send next, and it takes that bit back on a single data input during the same cycle. After a successful memory write, the surrounding control logic pulses a request, and the block sends a two-bit-period acknowledge burst made of quarter-bit pulses. Ordinary coded data never contains pulses that short. During reset the load is held off.

Top module: `rfid_readout_enc`

## Requirements
- R1: One bit lasts 64 carrier clocks when `fast_i` is 0 and 32 clocks when `fast_i` is 1. The coded level changes only at bit starts and at the mid-bit clock (clock 32 or 16 of the bit).
- R2: In user-memory mode (`mode_i` = 00 or 11) stream position k carries word k/16, bit k%16. The sequence is positions 0..127, then 0 again with no pause. Throughout a bit, `mem_word_o`/`mem_bit_o` show the address of the following bit, and `mem_data_i` is taken at the bit boundary.
- R3: In identifier mode (`mode_i` = 01) position k carries `id_i[k]` for k = 0..63, and the stream then repeats from bit 0.
- R4: Manchester (`biphase_i` = 0): the line level equals the data bit in the first half and its inverse in the second half. Line level high means load off (`mod_en_o` = 0).
- R5: Bi-phase (`biphase_i` = 1): the line level inverts at the start of every bit. It inverts again at mid-bit only for a 0. The level before the first bit after reset is high (load off).
- R6: In configuration mode (`mode_i` = 10) the stream is 128 bits long. Positions 0..15 carry `cfg_word_i` from bit 0 upward, and positions 16..127 are 0.
- R7: A pulse on `ack_req_i` takes effect at the next bit boundary. For two bit periods `mod_en_o` is then 1 in quarters 0 and 2 of each bit and 0 in quarters 1 and 3. The current stream then restarts at its bit 0. The bi-phase level is carried across the burst unchanged.
- R8: While `rst_ni` is 0, `mod_en_o` is 0. The first bit starts on the first clock edge after reset is released, and it is bit 0 of the selected stream (word 0 bit 0 in user mode).
- R9: A change of `mode_i` takes effect at the next bit boundary, and the new stream starts at its own bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock recovered from the carrier |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_i | input | 1 | Static: 1 selects 32 clocks per bit, 0 selects 64 |
| biphase_i | input | 1 | Static: 1 selects bi-phase coding, 0 selects Manchester |
| mode_i | input | 2 | Stream select: 00/11 user memory, 01 identifier, 10 configuration |
| ack_req_i | input | 1 | Pulse requesting an acknowledge burst |
| mem_word_o | output | 3 | Word address of the next user-memory bit |
| mem_bit_o | output | 4 | Bit index of the next user-memory bit |
| mem_data_i | input | 1 | Memory bit at the shown address |
| id_i | input | 64 | Fixed identifier |
| cfg_word_i | input | 16 | Configuration word |
| mod_en_o | output | 1 | 1 connects the modulator load |

## Verification
A stream position that is off by one shows up on the address outputs before the affected bit begins. It also shows up as a wrong half-bit level within one bit period of the slip. A miscounted bit timer moves the mid-bit or boundary transition, so the bench samples the last and first clock of each half. One wrong cycle is then visible in the bit where it happens. A bad acknowledge or mode-change state shows within a single bit: the burst pattern breaks, or the restart from bit 0 is missed. A bi-phase level flipped in error stays inverted for the rest of the stream.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

   typedef enum logic [1:0] {
      SRC_USER = 2'b00,
      SRC_ID   = 2'b01,
      SRC_CFG  = 2'b10
   } src_e;

   function automatic src_e decode_src(input logic [1:0] sel);
      case (sel)
         2'b01:   return SRC_ID;
         2'b10:   return SRC_CFG;
         default: return SRC_USER;
      endcase
   endfunction

endpackage

// File: rtl/rfe_bit_timer.sv
module rfe_bit_timer #(
   parameter int SLOW_CLKS   = 64,
   parameter int FAST_CLKS   = 32,
   parameter bit FAST_OPT_EN = 1'b1,
   localparam int CNT_W      = $clog2(SLOW_CLKS)
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       fast_i,
   output logic       bit_end_o,
   output logic       mid_end_o,
   output logic       half_o,
   output logic [1:0] quarter_o
);

   localparam int SW = CNT_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_c;
   logic [CNT_W-1:0] half_last_c;

   generate
      if (FAST_OPT_EN) begin : g_dual
         localparam int FW = $clog2(FAST_CLKS);
         always_comb begin
            if (fast_i) begin
               last_c      = CNT_W'(FAST_CLKS - 1);
               half_last_c = CNT_W'(FAST_CLKS / 2 - 1);
               half_o      = cnt_q[FW-1];
               quarter_o   = cnt_q[FW-1 -: 2];
            end else begin
               last_c      = CNT_W'(SLOW_CLKS - 1);
               half_last_c = CNT_W'(SLOW_CLKS / 2 - 1);
               half_o      = cnt_q[SW-1];
               quarter_o   = cnt_q[SW-1 -: 2];
            end
         end
      end else begin : g_single
         always_comb begin
            last_c      = CNT_W'(SLOW_CLKS - 1);
            half_last_c = CNT_W'(SLOW_CLKS / 2 - 1);
            half_o      = cnt_q[SW-1];
            quarter_o   = cnt_q[SW-1 -: 2];
         end
      end
   endgenerate

   // the reset value is the all-ones count, so the first edge after reset is a boundary
   assign bit_end_o = (cnt_q >= last_c);
   assign mid_end_o = (cnt_q == half_last_c);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '1;
      end else if (bit_end_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1
   wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_end_o |=> (cnt_q == '0));

   // R1
   mid_sep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mid_end_o |-> !bit_end_o);

endmodule

// File: rtl/rfe_stream_seq.sv
module rfe_stream_seq
   import rfe_pkg::*;
#(
   parameter int USER_WORDS = 8,
   parameter int WORD_BITS  = 16,
   parameter int ID_BITS    = 64,
   parameter int CFG_BITS   = 16,
   localparam int USER_LEN  = USER_WORDS * WORD_BITS,
   localparam int POS_W     = $clog2(USER_LEN),
   localparam int WADDR_W   = $clog2(USER_WORDS),
   localparam int BADDR_W   = $clog2(WORD_BITS),
   localparam int ID_W      = $clog2(ID_BITS)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                bit_end_i,
   input  logic [1:0]          mode_i,
   input  logic                ack_req_i,
   output logic [WADDR_W-1:0]  mem_word_o,
   output logic [BADDR_W-1:0]  mem_bit_o,
   input  logic                mem_data_i,
   input  logic [ID_BITS-1:0]  id_i,
   input  logic [CFG_BITS-1:0] cfg_word_i,
   output logic                cur_bit_o,
   output logic                adv_o,
   output logic                ack_o,
   output logic                run_o
);

   src_e             src_in, src_q;
   logic [POS_W-1:0] pos_q, pos_last, pos_inc, nxt_pos;
   logic             cur_bit_q, run_q, ack_q, ack_bit_q, ack_pend_q;
   logic             ack_last, ack_start, adv, sel_bit;
   logic [USER_LEN-1:0] cfg_vec;

   // configuration stream: word bits first, zero padding after
   generate
      for (genvar i = 0; i < USER_LEN; i++) begin : g_cfg
         if (i < CFG_BITS) begin : g_word
            assign cfg_vec[i] = cfg_word_i[i];
         end else begin : g_pad
            assign cfg_vec[i] = 1'b0;
         end
      end
   endgenerate

   assign src_in    = decode_src(mode_i);
   assign ack_last  = ack_q & ack_bit_q;
   assign ack_start = bit_end_i & ~ack_q & (ack_pend_q | ack_req_i);
   assign adv       = bit_end_i & ~ack_start & (~ack_q | ack_last);

   assign pos_last = (src_q == SRC_ID) ? POS_W'(ID_BITS - 1) : POS_W'(USER_LEN - 1);
   assign pos_inc  = (pos_q == pos_last) ? '0 : pos_q + 1'b1;
   assign nxt_pos  = (ack_q || (src_in != src_q)) ? '0 : pos_inc;

   assign mem_word_o = nxt_pos[POS_W-1:BADDR_W];
   assign mem_bit_o  = nxt_pos[BADDR_W-1:0];

   always_comb begin
      case (src_in)
         SRC_ID:  sel_bit = id_i[nxt_pos[ID_W-1:0]];
         SRC_CFG: sel_bit = cfg_vec[nxt_pos];
         default: sel_bit = mem_data_i;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         src_q      <= SRC_USER;
         pos_q      <= POS_W'(USER_LEN - 1);
         cur_bit_q  <= 1'b0;
         run_q      <= 1'b0;
         ack_q      <= 1'b0;
         ack_bit_q  <= 1'b0;
         ack_pend_q <= 1'b0;
      end else begin
         if (bit_end_i) begin
            run_q <= 1'b1;
         end
         if (adv) begin
            src_q     <= src_in;
            pos_q     <= nxt_pos;
            cur_bit_q <= sel_bit;
         end
         if (ack_start) begin
            ack_q     <= 1'b1;
            ack_bit_q <= 1'b0;
         end else if (bit_end_i && ack_q) begin
            if (ack_bit_q) begin
               ack_q <= 1'b0;
            end else begin
               ack_bit_q <= 1'b1;
            end
         end
         if (ack_start) begin
            ack_pend_q <= 1'b0;
         end else if (ack_req_i) begin
            ack_pend_q <= 1'b1;
         end
      end
   end

   assign cur_bit_o = cur_bit_q;
   assign adv_o     = adv;
   assign ack_o     = ack_q;
   assign run_o     = run_q;

   // R2
   user_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && run_q && !ack_q && src_q == SRC_USER && src_in == SRC_USER)
      |=> (pos_q == (($past(pos_q) == POS_W'(USER_LEN - 1)) ? '0 : $past(pos_q) + 1'b1)));

   // R3
   id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_q == SRC_ID) |-> (pos_q <= POS_W'(ID_BITS - 1)));

   // R6
   cfg_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && src_q == SRC_CFG && pos_q >= POS_W'(CFG_BITS)) |-> !cur_bit_q);

   // R7
   ack_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bit_end_i && ack_q && ack_bit_q) |=> (!ack_q && pos_q == '0));

   // R9
   mode_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && src_in != src_q) |=> (pos_q == '0 && src_q == $past(src_in)));

endmodule

// File: rtl/rfe_line_coder.sv
module rfe_line_coder #(
   parameter bit BIPHASE_EN = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       biphase_i,
   input  logic       run_i,
   input  logic       ack_i,
   input  logic       adv_i,
   input  logic       mid_end_i,
   input  logic       half_i,
   input  logic [1:0] quarter_i,
   input  logic       cur_bit_i,
   output logic       mod_en_o
);

   logic level_hi;
   logic data_hi;

   generate
      if (BIPHASE_EN) begin : g_both
         logic lvl_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               lvl_q <= 1'b1;
            end else if (biphase_i) begin
               if (adv_i) begin
                  lvl_q <= ~lvl_q;
               end else if (mid_end_i && run_i && !ack_i && !cur_bit_i) begin
                  lvl_q <= ~lvl_q;
               end
            end
         end
         assign data_hi = biphase_i ? lvl_q : (half_i ? ~cur_bit_i : cur_bit_i);

         // R5
         biph_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (run_i && biphase_i && adv_i && !ack_i) |=> (mod_en_o != $past(mod_en_o)));
      end else begin : g_manch
         assign data_hi = half_i ? ~cur_bit_i : cur_bit_i;
      end
   endgenerate

   always_comb begin
      if (ack_i) begin
         level_hi = quarter_i[0];
      end else if (!run_i) begin
         level_hi = 1'b1;
      end else begin
         level_hi = data_hi;
      end
   end

   assign mod_en_o = ~level_hi;

   // R4
   manch_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !ack_i && !biphase_i && mid_end_i) |=> (mod_en_o != $past(mod_en_o)));

   // R8
   idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |-> !mod_en_o);

endmodule

// File: rtl/rfid_readout_enc.sv
module rfid_readout_enc #(
   parameter int SLOW_BIT_CLKS = 64,
   parameter int FAST_BIT_CLKS = 32,
   parameter bit FAST_OPT_EN   = 1'b1,
   parameter bit BIPHASE_EN    = 1'b1,
   parameter int USER_WORDS    = 8,
   parameter int WORD_BITS     = 16,
   parameter int ID_BITS       = 64,
   parameter int CFG_BITS      = 16,
   localparam int WADDR_W      = $clog2(USER_WORDS),
   localparam int BADDR_W      = $clog2(WORD_BITS)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                fast_i,
   input  logic                biphase_i,
   input  logic [1:0]          mode_i,
   input  logic                ack_req_i,
   output logic [WADDR_W-1:0]  mem_word_o,
   output logic [BADDR_W-1:0]  mem_bit_o,
   input  logic                mem_data_i,
   input  logic [ID_BITS-1:0]  id_i,
   input  logic [CFG_BITS-1:0] cfg_word_i,
   output logic                mod_en_o
);

   localparam int USER_LEN = USER_WORDS * WORD_BITS;

   // elaboration-time parameter checks
   generate
      if ((SLOW_BIT_CLKS & (SLOW_BIT_CLKS - 1)) != 0 || SLOW_BIT_CLKS < 8) begin : g_bad_slow
         $fatal(1, "SLOW_BIT_CLKS must be a power of two of at least 8");
      end
      if ((FAST_BIT_CLKS & (FAST_BIT_CLKS - 1)) != 0 || FAST_BIT_CLKS < 8
          || FAST_BIT_CLKS >= SLOW_BIT_CLKS) begin : g_bad_fast
         $fatal(1, "FAST_BIT_CLKS must be a power of two, at least 8, below SLOW_BIT_CLKS");
      end
      if ((USER_WORDS & (USER_WORDS - 1)) != 0 || (WORD_BITS & (WORD_BITS - 1)) != 0
          || USER_WORDS < 2 || WORD_BITS < 2) begin : g_bad_user
         $fatal(1, "USER_WORDS and WORD_BITS must be powers of two of at least 2");
      end
      if ((ID_BITS & (ID_BITS - 1)) != 0 || ID_BITS < 2 || ID_BITS > USER_LEN) begin : g_bad_id
         $fatal(1, "ID_BITS must be a power of two not above the user stream length");
      end
      if (CFG_BITS < 1 || CFG_BITS > USER_LEN) begin : g_bad_cfg
         $fatal(1, "CFG_BITS must fit in the configuration stream");
      end
   endgenerate

   logic       bit_end, mid_end, half;
   logic [1:0] quarter;
   logic       cur_bit, adv, ack, run;

   rfe_bit_timer #(
      .SLOW_CLKS   (SLOW_BIT_CLKS),
      .FAST_CLKS   (FAST_BIT_CLKS),
      .FAST_OPT_EN (FAST_OPT_EN)
   ) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fast_i    (fast_i),
      .bit_end_o (bit_end),
      .mid_end_o (mid_end),
      .half_o    (half),
      .quarter_o (quarter)
   );

   rfe_stream_seq #(
      .USER_WORDS (USER_WORDS),
      .WORD_BITS  (WORD_BITS),
      .ID_BITS    (ID_BITS),
      .CFG_BITS   (CFG_BITS)
   ) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bit_end_i  (bit_end),
      .mode_i     (mode_i),
      .ack_req_i  (ack_req_i),
      .mem_word_o (mem_word_o),
      .mem_bit_o  (mem_bit_o),
      .mem_data_i (mem_data_i),
      .id_i       (id_i),
      .cfg_word_i (cfg_word_i),
      .cur_bit_o  (cur_bit),
      .adv_o      (adv),
      .ack_o      (ack),
      .run_o      (run)
   );

   rfe_line_coder #(
      .BIPHASE_EN (BIPHASE_EN)
   ) u_coder (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .biphase_i (biphase_i),
      .run_i     (run),
      .ack_i     (ack),
      .adv_i     (adv),
      .mid_end_i (mid_end),
      .half_i    (half),
      .quarter_i (quarter),
      .cur_bit_i (cur_bit),
      .mod_en_o  (mod_en_o)
   );

   // R7
   ack_first_q_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bit_end && ack_req_i && !ack) |=> mod_en_o);

endmodule

// File: tb/rfid_readout_enc_tb.sv
module rfid_readout_enc_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fast = 1'b0;
   logic        bip = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        ack_req = 1'b0;
   logic [2:0]  mem_word;
   logic [3:0]  mem_bit;
   logic        mem_data;
   logic [63:0] id_val = 64'h9E37_79B9_7F4A_7C15;
   logic [15:0] cfg_val = 16'hC3A5;
   logic        mod_en;

   logic [15:0] mem [8];

   int  chk_n = 0;
   int  err_n = 0;
   int  len = 64;
   bit  lvl = 1'b1;
   bit  done = 1'b0;
   logic [1:0] mode_nx = 2'b00;

   always #10 clk = ~clk;

   assign mem_data = mem[mem_word][mem_bit];

   rfid_readout_enc u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .fast_i     (fast),
      .biphase_i  (bip),
      .mode_i     (mode),
      .ack_req_i  (ack_req),
      .mem_word_o (mem_word),
      .mem_bit_o  (mem_bit),
      .mem_data_i (mem_data),
      .id_i       (id_val),
      .cfg_word_i (cfg_val),
      .mod_en_o   (mod_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      chk_n++;
      if (!ok) begin
         err_n++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit user_bit(input int k);
      return mem[(k % 128) / 16][k % 16];
   endfunction

   function automatic bit cfg_bit(input int k);
      return ((k % 128) < 16) ? cfg_val[k % 128] : 1'b0;
   endfunction

   // reset with the given static options; checks the reset state (R8)
   task automatic do_reset(input bit f, input bit b, input logic [1:0] m);
      @(negedge clk);
      rst_n = 1'b0;
      fast = f;
      bip = b;
      mode = m;
      ack_req = 1'b0;
      len = f ? 32 : 64;
      lvl = 1'b1;
      repeat (3) @(negedge clk);
      check(mod_en == 1'b0, "R8 load off in reset", int'(mod_en), 0);
      if (m == 2'b00) begin
         check({mem_word, mem_bit} == 7'd0, "R8 R2 first address word 0 bit 0",
               int'({mem_word, mem_bit}), 0);
      end
      rst_n = 1'b1;
   endtask

   // one coded data bit; act 1 = change mode at mid-bit, 2 = pulse ack at mid-bit
   task automatic exp_bit(input bit b, input int act, input bit chk_addr, input int exp_addr,
                          input string req);
      for (int p = 0; p < len; p++) begin
         @(negedge clk);
         if (p == 0 && bip) lvl = ~lvl;
         if (p == len / 2 && bip && !b) lvl = ~lvl;
         if (p == 0 && chk_addr) begin
            check(int'({mem_word, mem_bit}) == exp_addr, {req, " next address"},
                  int'({mem_word, mem_bit}), exp_addr);
         end
         if (p == 0 || p == len / 2 - 1 || p == len / 2 || p == len - 1) begin
            bit e;
            if (bip) e = ~lvl;
            else e = (p < len / 2) ? ~b : b;
            check(mod_en == e, {req, " R1 coded level"}, int'(mod_en), int'(e));
         end
         if (p == len / 2 && act == 1) mode = mode_nx;
         if (p == len / 2 && act == 2) ack_req = 1'b1;
         if (p == len / 2 + 1) ack_req = 1'b0;
      end
   endtask

   task automatic exp_ack(input string req);
      for (int p = 0; p < 2 * len; p++) begin
         int q;
         int qp;
         @(negedge clk);
         q = p / (len / 4);
         qp = p % (len / 4);
         if (qp == 0 || qp == len / 4 - 1) begin
            check(mod_en == ((q % 2) == 0), {req, " R7 burst quarter"}, int'(mod_en),
                  int'((q % 2) == 0));
         end
      end
   endtask

   task automatic t_user_manch;
      do_reset(1'b0, 1'b0, 2'b00);
      for (int k = 0; k < 144; k++) begin
         exp_bit(user_bit(k), 0, 1'b1, (k + 1) % 128, "R2 R4 R8 user stream");
      end
   endtask

   task automatic t_id_fast;
      do_reset(1'b1, 1'b0, 2'b01);
      for (int k = 0; k < 72; k++) begin
         exp_bit(id_val[k % 64], 0, 1'b0, 0, "R3 R8 id stream fast");
      end
   endtask

   task automatic t_cfg_biphase;
      do_reset(1'b0, 1'b1, 2'b00);
      mode_nx = 2'b10;
      for (int k = 0; k < 4; k++) begin
         exp_bit(user_bit(k), (k == 3) ? 1 : 0, 1'b0, 0, "R5 user biphase");
      end
      for (int k = 0; k < 130; k++) begin
         exp_bit(cfg_bit(k), 0, 1'b0, 0, "R6 R9 R5 config stream");
      end
   endtask

   task automatic t_ack_manch;
      do_reset(1'b0, 1'b0, 2'b00);
      for (int k = 0; k < 3; k++) begin
         exp_bit(user_bit(k), (k == 2) ? 2 : 0, 1'b1, k + 1, "R7 before burst");
      end
      exp_ack("R7 manchester");
      for (int k = 0; k < 3; k++) begin
         exp_bit(user_bit(k), 0, 1'b1, k + 1, "R7 restart user");
      end
   endtask

   task automatic t_ack_biphase;
      do_reset(1'b1, 1'b1, 2'b01);
      for (int k = 0; k < 2; k++) begin
         exp_bit(id_val[k], (k == 1) ? 2 : 0, 1'b0, 0, "R7 R5 id before burst");
      end
      exp_ack("R7 biphase");
      for (int k = 0; k < 3; k++) begin
         exp_bit(id_val[k], 0, 1'b0, 0, "R7 R5 id after burst");
      end
   endtask

   task automatic t_mode_alt;
      do_reset(1'b1, 1'b0, 2'b01);
      mode_nx = 2'b11;
      for (int k = 0; k < 3; k++) begin
         exp_bit(id_val[k], (k == 2) ? 1 : 0, 1'b0, 0, "R9 id before switch");
      end
      for (int k = 0; k < 5; k++) begin
         exp_bit(user_bit(k), 0, 1'b1, k + 1, "R9 code 11 user restart");
      end
   endtask

   initial begin
      for (int w = 0; w < 8; w++) begin
         mem[w] = 16'h1F2E + 16'(w) * 16'h3C5B;
      end
      t_user_manch();
      t_id_fast();
      t_cfg_biphase();
      t_ack_manch();
      t_ack_biphase();
      t_mode_alt();
      do_reset(1'b0, 1'b0, 2'b00);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", chk_n, err_n);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk_n++;
         err_n++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", chk_n, err_n);
         $finish;
      end
   end

endmodule